// File: doc/BRIEF.md
# Event Translation Sequencer

This block turns a (device, event) pair into a pending-interrupt update aimed at one processor. A request arrives with a kind: a doorbell write, or a queued trigger, clear or discard command. The sequencer then reads a chain of memory entries, each one depending on the one before it. It reads the device entry first. That entry gives the base of a per-device translation table, and the sequencer reads the translation entry from there. The translation entry names a collection, and the collection entry names the target processor. Each step is validated before the next begins. A request that passes every check produces a one-cycle set or clear pulse carrying the processor number and interrupt ID. A discard then also wipes the translation entry in memory.

Every request ends in a one-cycle completion pulse that says either "continue" or "stall". Malformed parameters and invalid entries give "continue" and leave the pending state untouched. Memory faults give "stall", which tells the command front end to stop consuming its queue. The memory addresses of device and collection entries come from an external table walker. The walker is given a table select and an index, and answers in the same cycle with an address or a miss.

Top module: `evt_xlate_seq`

## Requirements
- R1: A request is taken only when `busy` is low. `busy` is high from the cycle after acceptance up to and including the cycle of `done_valid`. A request offered while `busy` is high has no effect.
- R2: The kind encoding is 0 = doorbell, 1 = trigger, 2 = clear, 3 = discard. A doorbell request is taken only while `en` is high. Otherwise it causes no busy, no memory access, no pulse and no completion.
- R3: A device ID at or above `cfg_dev_cap` completes as continue, with no memory access and no pend pulse.
- R4: The device entry is a 64-bit read, laid out as follows: bit 0 is valid, bits 5:1 are size, and bits 49:6 hold translation-table address bits 51:8. A walker miss or a clear valid bit completes as continue with no pend pulse.
- R5: A device accepts event IDs below 2^(size+1). A larger event ID completes as continue with no pend pulse.
- R6: The translation entry sits at base + event*12. It is read as a 64-bit low word at that address, then a 32-bit high word at +8. The low word holds valid in bit 0, physical type in bit 1 (must be 1) and the interrupt ID in bits 25:2. The high word holds the collection ID in bits 15:0. If valid is clear or the type is not physical, the request completes as continue with no pend pulse.
- R7: A collection ID at or above `cfg_coll_cap`, a walker miss on the collection entry, or a collection entry whose bit 0 (valid) is clear, completes as continue with no pend pulse.
- R8: The target processor is bits 8:1 of the collection entry. A value at or above `cfg_cpu_cnt` completes as continue with no pend pulse.
- R9: A fully valid request gives one single-cycle `pend_valid` pulse with the entry's processor and interrupt ID. `pend_set` is 1 for doorbell and trigger and 0 for clear and discard. The request then completes as continue.
- R10: After its pulse, a discard writes zeros as a 64-bit word at the entry address and then as a 32-bit word at +8. A write error on either word completes as stall.
- R11: A read error on any entry completes as stall and gives no pend pulse.
- R12: Reads are issued in the order device, translation low, translation high, collection. Each request holds its address and direction steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Unit enable, gates doorbell requests |
| cfg_dev_cap | input | DEV_W+1 | Number of device entries |
| cfg_coll_cap | input | COL_W+1 | Number of collection entries |
| cfg_cpu_cnt | input | CPU_W+1 | Number of processors |
| req_valid | input | 1 | Request offered |
| req_kind | input | 2 | Request kind |
| req_dev | input | DEV_W | Device ID |
| req_evt | input | EVT_W | Event ID |
| busy | output | 1 | Request in progress |
| tbl_sel | output | 1 | Walker table: 0 device, 1 collection |
| tbl_idx | output | IDX_W | Walker index |
| tbl_addr | input | AW | Walker entry address |
| tbl_miss | input | 1 | Walker found no entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for 64-bit access, 0 for 32-bit |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access faulted, valid with ack |
| mem_rdata | input | 64 | Read data, valid with ack |
| pend_valid | output | 1 | Pending update pulse |
| pend_set | output | 1 | 1 set, 0 clear |
| pend_cpu | output | CPU_W | Target processor |
| pend_intid | output | INT_W | Interrupt ID |
| done_valid | output | 1 | Completion pulse |
| done_stall | output | 1 | 1 stall, 0 continue |

## Verification
A single well-formed table set is run through all four kinds. This separates set from clear and shows that only a discard produces the two zero write-backs. Next, one field at a time is corrupted: the device ID bound, device valid, the event range (highest legal event against the first illegal one), translation validity and type, the collection bound and validity, walker misses, and the processor bound. Each of these must give continue with no pulse. Faults injected on a read and on a write-back must give stall instead, which separates the ignore path from the stall path. Overlapping and disabled doorbell requests show that the pulse count stays exact.

// File: rtl/evt_xlate_pkg.sv
package evt_xlate_pkg;
    // Request kinds as encoded on req_kind
    typedef enum logic [1:0] {
        K_DOORBELL = 2'd0,
        K_TRIGGER  = 2'd1,
        K_CLEAR    = 2'd2,
        K_DISCARD  = 2'd3
    } xl_kind_e;

    // Sequencer states, in lookup order
    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_TLO, S_THI, S_COL, S_NOTE, S_WLO, S_WHI, S_FIN
    } xl_state_e;

    localparam int HI_WORD_OFS = 8;   // byte offset of the translation high word
    localparam int SIZE_LSB    = 1;   // device entry size field
    localparam int SIZE_BITS   = 5;
    localparam int ITT_LSB     = 6;   // device entry base address field
    localparam int ITT_BITS    = 44;  // holds address bits 51:8
endpackage

// File: rtl/xl_entry_dec.sv
// Field decoder for the three entry formats read by the sequencer.
// Assumes the caller only uses the outputs that match the entry being read.
module xl_entry_dec
    import evt_xlate_pkg::*;
#(
    parameter int AW    = 52,
    parameter int INT_W = 24,
    parameter int COL_W = 16,
    parameter int CPU_W = 8
) (
    input  logic [63:0]          word,
    output logic                 dev_ok,
    output logic [SIZE_BITS-1:0] dev_size,
    output logic [AW-1:0]        dev_base,
    output logic                 tlo_ok,
    output logic [INT_W-1:0]     tlo_intid,
    output logic [COL_W-1:0]     thi_coll,
    output logic                 col_ok,
    output logic [CPU_W-1:0]     col_cpu
);
    // Device entry: valid, size, base address bits 51:8
    always_comb begin
        dev_ok   = word[0];
        dev_size = word[SIZE_LSB +: SIZE_BITS];
        dev_base = AW'({word[ITT_LSB +: ITT_BITS], 8'h00});
    end

    // Translation words: low carries valid/type/ID, high carries collection
    always_comb begin
        tlo_ok    = word[0] & word[1];
        tlo_intid = word[2 +: INT_W];
        thi_coll  = word[COL_W-1:0];
    end

    // Collection entry: valid and processor number
    always_comb begin
        col_ok  = word[0];
        col_cpu = word[1 +: CPU_W];
    end

    logic unused_hi;
    assign unused_hi = ^word[63:50];
endmodule

// File: rtl/xl_bounds.sv
// Range checks on identifiers against the configured capacities.
// Assumes capacities are held steady while a request is in flight.
module xl_bounds
    import evt_xlate_pkg::*;
#(
    parameter int DEV_W = 16,
    parameter int EVT_W = 16,
    parameter int COL_W = 16,
    parameter int CPU_W = 8
) (
    input  logic [DEV_W-1:0]     dev,
    input  logic [DEV_W:0]       dev_cap,
    input  logic [EVT_W-1:0]     evt,
    input  logic [SIZE_BITS-1:0] size,
    input  logic [COL_W-1:0]     coll,
    input  logic [COL_W:0]       coll_cap,
    input  logic [CPU_W-1:0]     cpu,
    input  logic [CPU_W:0]       cpu_cnt,
    output logic                 dev_in,
    output logic                 evt_in,
    output logic                 coll_in,
    output logic                 cpu_in
);
    localparam int EXT_W = 34;

    logic [EXT_W-1:0] evt_ext;
    logic [5:0]       shamt;

    // Event is legal when nothing survives a shift by size+1
    always_comb begin
        evt_ext = EXT_W'(evt);
        shamt   = 6'(size) + 6'd1;
        evt_in  = (evt_ext >> shamt) == '0;
    end

    // Identifier bounds against capacities
    always_comb begin
        dev_in  = {1'b0, dev}  < dev_cap;
        coll_in = {1'b0, coll} < coll_cap;
        cpu_in  = {1'b0, cpu}  < cpu_cnt;
    end
endmodule

// File: rtl/evt_xlate_seq.sv
// Event translation sequencer: device -> translation -> collection lookup,
// then a pending set/clear pulse; discard also zeroes the translation entry.
// Assumes a walker answering combinationally and a memory that holds
// mem_ack for one cycle per request.
module evt_xlate_seq
    import evt_xlate_pkg::*;
#(
    parameter int AW    = 52,
    parameter int DEV_W = 16,
    parameter int EVT_W = 16,
    parameter int COL_W = 16,
    parameter int CPU_W = 8,
    parameter int INT_W = 24,
    localparam int IDX_W = (DEV_W > COL_W) ? DEV_W : COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DEV_W:0]   cfg_dev_cap,
    input  logic [COL_W:0]   cfg_coll_cap,
    input  logic [CPU_W:0]   cfg_cpu_cnt,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [DEV_W-1:0] req_dev,
    input  logic [EVT_W-1:0] req_evt,
    output logic             busy,
    output logic             tbl_sel,
    output logic [IDX_W-1:0] tbl_idx,
    input  logic [AW-1:0]    tbl_addr,
    input  logic             tbl_miss,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [AW-1:0]    mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [63:0]      mem_rdata,
    output logic             pend_valid,
    output logic             pend_set,
    output logic [CPU_W-1:0] pend_cpu,
    output logic [INT_W-1:0] pend_intid,
    output logic             done_valid,
    output logic             done_stall
);
    xl_state_e        st;
    xl_kind_e         kind_q;
    logic [DEV_W-1:0] dev_q;
    logic [EVT_W-1:0] evt_q;
    logic [AW-1:0]    ent_q;
    logic [INT_W-1:0] intid_q;
    logic             tlo_ok_q;
    logic [COL_W-1:0] coll_q;
    logic [CPU_W-1:0] cpu_q;
    logic             stall_q;

    logic                 d_ok, t_ok, c_ok;
    logic [SIZE_BITS-1:0] d_size;
    logic [AW-1:0]        d_base;
    logic [INT_W-1:0]     t_intid;
    logic [COL_W-1:0]     t_coll;
    logic [CPU_W-1:0]     c_cpu;
    logic                 dev_in, evt_in, coll_in, cpu_in;
    logic                 take;
    logic [AW-1:0]        ent_addr;

    xl_entry_dec #(.AW(AW), .INT_W(INT_W), .COL_W(COL_W), .CPU_W(CPU_W)) u_dec (
        .word(mem_rdata), .dev_ok(d_ok), .dev_size(d_size), .dev_base(d_base),
        .tlo_ok(t_ok), .tlo_intid(t_intid), .thi_coll(t_coll),
        .col_ok(c_ok), .col_cpu(c_cpu)
    );

    xl_bounds #(.DEV_W(DEV_W), .EVT_W(EVT_W), .COL_W(COL_W), .CPU_W(CPU_W)) u_bnd (
        .dev(req_dev), .dev_cap(cfg_dev_cap), .evt(evt_q), .size(d_size),
        .coll(t_coll), .coll_cap(cfg_coll_cap), .cpu(c_cpu), .cpu_cnt(cfg_cpu_cnt),
        .dev_in(dev_in), .evt_in(evt_in), .coll_in(coll_in), .cpu_in(cpu_in)
    );

    // Acceptance gate and translation entry address (base + event*12)
    always_comb begin
        take     = (st == S_IDLE) && req_valid && (req_kind != K_DOORBELL || en);
        ent_addr = d_base + (AW'(evt_q) << 3) + (AW'(evt_q) << 2);
    end

    // Lookup sequence with per-step validation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; kind_q <= K_DOORBELL; dev_q <= '0; evt_q <= '0;
            ent_q <= '0; intid_q <= '0; tlo_ok_q <= 1'b0; coll_q <= '0;
            cpu_q <= '0; stall_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (take) begin
                    kind_q  <= xl_kind_e'(req_kind);
                    dev_q   <= req_dev;
                    evt_q   <= req_evt;
                    stall_q <= 1'b0;
                    st      <= dev_in ? S_DEV : S_FIN;
                end
                S_DEV: if (tbl_miss) st <= S_FIN;
                    else if (mem_ack) begin
                        if (mem_err) begin stall_q <= 1'b1; st <= S_FIN; end
                        else if (!d_ok || !evt_in) st <= S_FIN;
                        else begin ent_q <= ent_addr; st <= S_TLO; end
                    end
                S_TLO: if (mem_ack) begin
                    if (mem_err) begin stall_q <= 1'b1; st <= S_FIN; end
                    else begin tlo_ok_q <= t_ok; intid_q <= t_intid; st <= S_THI; end
                end
                S_THI: if (mem_ack) begin
                    if (mem_err) begin stall_q <= 1'b1; st <= S_FIN; end
                    else if (!tlo_ok_q || !coll_in) st <= S_FIN;
                    else begin coll_q <= t_coll; st <= S_COL; end
                end
                S_COL: if (tbl_miss) st <= S_FIN;
                    else if (mem_ack) begin
                        if (mem_err) begin stall_q <= 1'b1; st <= S_FIN; end
                        else if (!c_ok || !cpu_in) st <= S_FIN;
                        else begin cpu_q <= c_cpu; st <= S_NOTE; end
                    end
                S_NOTE: st <= (kind_q == K_DISCARD) ? S_WLO : S_FIN;
                S_WLO: if (mem_ack) begin
                    if (mem_err) begin stall_q <= 1'b1; st <= S_FIN; end
                    else st <= S_WHI;
                end
                S_WHI: if (mem_ack) begin
                    stall_q <= mem_err;
                    st      <= S_FIN;
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Walker and memory port drive from the current state
    always_comb begin
        tbl_sel   = (st == S_COL);
        tbl_idx   = (st == S_COL) ? IDX_W'(coll_q) : IDX_W'(dev_q);
        mem_req   = ((st == S_DEV || st == S_COL) && !tbl_miss) ||
                    st == S_TLO || st == S_THI || st == S_WLO || st == S_WHI;
        mem_we    = (st == S_WLO) || (st == S_WHI);
        mem_wide  = (st != S_THI) && (st != S_WHI);
        mem_wdata = '0;
        case (st)
            S_DEV, S_COL: mem_addr = tbl_addr;
            S_THI, S_WHI: mem_addr = ent_q + AW'(HI_WORD_OFS);
            default:      mem_addr = ent_q;
        endcase
    end

    // Result outputs
    always_comb begin
        busy       = (st != S_IDLE);
        pend_valid = (st == S_NOTE);
        pend_set   = (kind_q == K_DOORBELL) || (kind_q == K_TRIGGER);
        pend_cpu   = cpu_q;
        pend_intid = intid_q;
        done_valid = (st == S_FIN);
        done_stall = stall_q;
    end

    // R12: an outstanding access keeps its address and direction
    p_hold_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R1: completion frees the sequencer on the next cycle
    p_done_frees_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !busy);

    // R9: a pending update lasts exactly one cycle
    p_pend_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> !pend_valid);

    // R8: pulse never targets a processor outside the configured count
    p_pend_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ({1'b0, pend_cpu} < cfg_cpu_cnt));

    // R10: writes only happen on behalf of a discard
    p_write_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> kind_q == K_DISCARD);

    // R2: a doorbell only starts while enabled
    p_bell_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && kind_q == K_DOORBELL |-> $past(en));
endmodule

// File: tb/evt_xlate_seq_tb.sv
module evt_xlate_seq_tb;
    localparam int AW = 52;
    localparam logic [AW-1:0] DEV_BASE = 52'h1000;
    localparam logic [AW-1:0] COL_BASE = 52'h2000;
    localparam logic [AW-1:0] ITT      = 52'h123400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic [16:0] cfg_dev_cap = 17'd16;
    logic [16:0] cfg_coll_cap = 17'd8;
    logic [8:0]  cfg_cpu_cnt = 9'd4;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [15:0] req_dev = '0, req_evt = '0;
    logic busy, tbl_sel, tbl_miss, mem_req, mem_we, mem_wide;
    logic [15:0] tbl_idx;
    logic [AW-1:0] tbl_addr, mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic mem_ack = 1'b0, mem_err = 1'b0;
    logic pend_valid, pend_set, done_valid, done_stall;
    logic [7:0] pend_cpu;
    logic [23:0] pend_intid;

    evt_xlate_seq u_dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int total = 0, bad = 0;
    logic [63:0] dte_w, lo_w, hi_w, cte_w;
    logic miss_dev = 0, miss_col = 0;
    logic err_on = 0;
    logic [AW-1:0] err_addr = '0;
    int rd_cnt, wr_cnt, pend_cnt, done_cnt;
    logic [AW-1:0] rd_log [0:7];
    logic [AW-1:0] wr_log [0:3];
    logic last_set, last_stall, last_wide1;
    logic [7:0] last_cpu;
    logic [23:0] last_intid;

    assign tbl_addr = tbl_sel ? COL_BASE + {33'b0, tbl_idx, 3'b0} : DEV_BASE + {33'b0, tbl_idx, 3'b0};
    assign tbl_miss = tbl_sel ? miss_col : miss_dev;

    function automatic logic [63:0] mk_dte(input logic v, input logic [4:0] sz, input logic [AW-1:0] b);
        return {14'b0, b[51:8], sz, v};
    endfunction
    function automatic logic [63:0] mk_lo(input logic v, input logic ph, input logic [23:0] id);
        return {14'b0, 24'h3ff, id, ph, v};
    endfunction
    function automatic logic [63:0] mk_cte(input logic v, input logic [7:0] cpu);
        return {55'b0, cpu, v};
    endfunction

    // Memory responder and event monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_err <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_err <= err_on && (mem_addr == err_addr);
            if (mem_we) begin
                if (wr_cnt < 4) wr_log[wr_cnt] = mem_addr;
                if (wr_cnt == 0) last_wide1 = mem_wide;
                wr_cnt++;
            end else begin
                if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
                if (mem_addr >= ITT) mem_rdata <= (((mem_addr - ITT) % 12) == 0) ? lo_w : hi_w;
                else if (mem_addr >= COL_BASE) mem_rdata <= cte_w;
                else mem_rdata <= dte_w;
            end
        end else begin
            mem_ack <= 1'b0; mem_err <= 1'b0;
        end
        if (rst_n && pend_valid) begin
            pend_cnt++; last_set = pend_set; last_cpu = pend_cpu; last_intid = pend_intid;
        end
        if (rst_n && done_valid) begin
            done_cnt++; last_stall = done_stall;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        dte_w = mk_dte(1, 5'd2, ITT);
        lo_w  = mk_lo(1, 1, 24'h2005);
        hi_w  = 64'd5;
        cte_w = mk_cte(1, 8'd2);
        miss_dev = 0; miss_col = 0; err_on = 0; en = 1;
    endtask

    task automatic issue(input logic [1:0] k, input logic [15:0] d, input logic [15:0] e);
        rd_cnt = 0; wr_cnt = 0; pend_cnt = 0; done_cnt = 0;
        @(negedge clk);
        req_valid = 1; req_kind = k; req_dev = d; req_evt = e;
        @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
    endtask

    task automatic expect_ignore(input string tag, input int reads);
        chk(done_cnt == 1 && last_stall == 0, tag, {last_stall, 31'b0, 32'(done_cnt)}, 64'd1);
        chk(pend_cnt == 0, tag, 64'(pend_cnt), 64'd0);
        if (reads >= 0) chk(rd_cnt == reads, tag, 64'(rd_cnt), 64'(reads));
    endtask

    task automatic t_reset();
        chk(!busy && !pend_valid && !done_valid && !mem_req, "R1 reset idle",
            {busy, pend_valid, done_valid, mem_req}, 64'd0);
    endtask

    task automatic t_trigger();
        defaults();
        issue(2'd1, 16'd3, 16'd5);
        chk(pend_cnt == 1 && last_set == 1, "R9 trigger sets", {last_set, 8'(pend_cnt)}, {1'b1, 8'd1});
        chk(last_cpu == 2 && last_intid == 24'h2005, "R9 cpu/intid", {last_cpu, last_intid}, {8'd2, 24'h2005});
        chk(done_cnt == 1 && last_stall == 0 && wr_cnt == 0, "R9 continue no write",
            {last_stall, 8'(wr_cnt)}, 64'd0);
        chk(rd_cnt == 4 && rd_log[0] == DEV_BASE + 24 && rd_log[1] == ITT + 60 &&
            rd_log[2] == ITT + 68 && rd_log[3] == COL_BASE + 40, "R12 read order R6 address",
            rd_log[1], ITT + 60);
    endtask

    task automatic t_clear();
        defaults();
        issue(2'd2, 16'd3, 16'd5);
        chk(pend_cnt == 1 && last_set == 0, "R9 clear clears", {last_set, 8'(pend_cnt)}, {1'b0, 8'd1});
    endtask

    task automatic t_discard();
        defaults();
        issue(2'd3, 16'd3, 16'd1);
        chk(pend_cnt == 1 && last_set == 0, "R10 discard clears", {last_set, 8'(pend_cnt)}, {1'b0, 8'd1});
        chk(wr_cnt == 2 && wr_log[0] == ITT + 12 && wr_log[1] == ITT + 20 && last_wide1,
            "R10 zero write-back", wr_log[1], ITT + 20);
        chk(last_stall == 0, "R10 discard continue", 64'(last_stall), 64'd0);
        defaults(); err_on = 1; err_addr = ITT + 20;
        issue(2'd3, 16'd3, 16'd1);
        chk(done_cnt == 1 && last_stall == 1, "R10 write error stalls", 64'(last_stall), 64'd1);
    endtask

    task automatic t_dev_range();
        defaults();
        issue(2'd1, 16'd16, 16'd0);
        expect_ignore("R3 device at capacity", 0);
        defaults(); dte_w = mk_dte(0, 5'd2, ITT);
        issue(2'd1, 16'd3, 16'd0);
        expect_ignore("R4 device invalid", 1);
        defaults(); miss_dev = 1;
        issue(2'd1, 16'd3, 16'd0);
        expect_ignore("R4 device walker miss", 0);
    endtask

    task automatic t_evt_range();
        defaults();
        issue(2'd1, 16'd3, 16'd8);
        expect_ignore("R5 event 8 with size 2", 1);
        defaults();
        issue(2'd1, 16'd3, 16'd7);
        chk(pend_cnt == 1, "R5 event 7 accepted", 64'(pend_cnt), 64'd1);
    endtask

    task automatic t_ite();
        defaults(); lo_w = mk_lo(0, 1, 24'h2005);
        issue(2'd1, 16'd3, 16'd2);
        expect_ignore("R6 entry invalid", 3);
        defaults(); lo_w = mk_lo(1, 0, 24'h2005);
        issue(2'd1, 16'd3, 16'd2);
        expect_ignore("R6 entry not physical", 3);
    endtask

    task automatic t_coll();
        defaults(); hi_w = 64'd8;
        issue(2'd1, 16'd3, 16'd2);
        expect_ignore("R7 collection at capacity", 3);
        defaults(); cte_w = mk_cte(0, 8'd2);
        issue(2'd1, 16'd3, 16'd2);
        expect_ignore("R7 collection invalid", 4);
        defaults(); miss_col = 1;
        issue(2'd1, 16'd3, 16'd2);
        expect_ignore("R7 collection walker miss", 3);
    endtask

    task automatic t_cpu();
        defaults(); cte_w = mk_cte(1, 8'd4);
        issue(2'd1, 16'd3, 16'd2);
        expect_ignore("R8 processor at count", 4);
        defaults(); cte_w = mk_cte(1, 8'd3);
        issue(2'd1, 16'd3, 16'd2);
        chk(pend_cnt == 1 && last_cpu == 3, "R8 highest processor", 64'(last_cpu), 64'd3);
    endtask

    task automatic t_read_err();
        defaults(); err_on = 1; err_addr = ITT + 24;
        issue(2'd1, 16'd3, 16'd2);
        chk(done_cnt == 1 && last_stall == 1 && pend_cnt == 0, "R11 read error stalls",
            {last_stall, 8'(pend_cnt)}, {1'b1, 8'd0});
        defaults(); err_on = 1; err_addr = DEV_BASE + 24;
        issue(2'd2, 16'd3, 16'd2);
        chk(last_stall == 1 && pend_cnt == 0, "R11 device read error", 64'(last_stall), 64'd1);
    endtask

    task automatic t_doorbell();
        defaults(); en = 0;
        issue(2'd0, 16'd3, 16'd2);
        chk(done_cnt == 0 && pend_cnt == 0 && rd_cnt == 0, "R2 doorbell disabled",
            64'(done_cnt + pend_cnt + rd_cnt), 64'd0);
        defaults();
        issue(2'd0, 16'd3, 16'd2);
        chk(pend_cnt == 1 && last_set == 1, "R2 doorbell enabled sets", 64'(last_set), 64'd1);
    endtask

    task automatic t_busy();
        defaults();
        rd_cnt = 0; wr_cnt = 0; pend_cnt = 0; done_cnt = 0;
        @(negedge clk);
        req_valid = 1; req_kind = 2'd1; req_dev = 16'd3; req_evt = 16'd2;
        @(negedge clk);
        chk(busy == 1, "R1 busy after accept", 64'(busy), 64'd1);
        req_evt = 16'd4;     // still offered while busy
        @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
        chk(pend_cnt == 1 && done_cnt == 1 && !busy, "R1 second request ignored",
            64'(pend_cnt), 64'd1);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_trigger();
        t_clear();
        t_discard();
        t_dev_range();
        t_evt_range();
        t_ite();
        t_coll();
        t_cpu();
        t_read_err();
        t_doorbell();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule